// File: doc/BRIEF.md
# Timebase-Sharing Watchdog

This block is a watchdog that borrows one compare channel of a free-running 16-bit timebase counter. The upper byte of the counter is compared each cycle with a stored deadline byte. When the two are equal and the watchdog is armed, the block raises a one-cycle reset request. Software keeps the system alive by writing any value to the deadline register. That write moves the deadline to the current counter upper byte plus a programmable offset byte, so every service grants a fresh, relative window.

The watchdog comes out of reset armed. While it is armed it takes over the shared timebase:

- the counter is forced to run;
- the counter bytes cannot be written;
- the clock-select and idle-suspend settings are frozen;
- the channel mode is pinned to software-timer mode.

Clearing the arm bit releases every lock. The counter then follows the software run bit again.

Register addresses on the bus:

| Address | Register |
|---|---|
| 0 | control |
| 1 | run |
| 2 | counter low byte |
| 3 | counter high byte |
| 4 | channel mode |
| 5 | offset |
| 6 | deadline |

Reads are combinational from `bus_addr`. Writes take effect at the rising clock edge while `bus_wr` is high.

Top module: `wdog_timebase`

## Requirements
- R1: After reset the control register reads 0x01, and the counter, offset, deadline and run registers read 0. The channel mode reads 0x48. Because the counter upper byte and the deadline are then both 0, `wdt_req` pulses at the first clock edge after reset is released.
- R2: `wdt_req` is high for exactly one cycle, at the edge that follows the first cycle in which the armed deadline equals the counter upper byte. It does not pulse again while that equality persists.
- R3: A write of any data to address 6 loads the deadline with (counter upper byte + offset) mod 256. The counter upper byte used is the value before that same edge's increment.
- R4: While armed, the counter advances by one on every edge with `tb_tick` high, whatever the run bit holds. The run register (address 1, bit 0) reads back only the value software wrote, so it reads 0 if software never set it.
- R5: Writes to addresses 2 and 3 are ignored while armed. While disarmed they load the counter low and high bytes, and the write takes precedence over an increment in the same cycle.
- R6: The control register uses bit 0 for arm, bits 3:1 for clock select (driven on `clk_sel`) and bit 4 for idle suspend. While armed, a control write changes only bit 0.
- R7: While armed, the channel mode (address 4) is held at 0x48 and writes to it are ignored. Once disarmed it is freely writable.
- R8: Writing 0 to control bit 0 disarms the watchdog. While disarmed no request is issued, even when the deadline equals the counter upper byte, and the counter advances only when the run bit is 1.
- R9: The offset register (address 5) is writable and reads back at all times, armed or not.
- R10: When idle suspend is set and `cpu_idle` is high, the counter holds its value even on ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tb_tick | input | 1 | Timebase count enable from the prescaler |
| cpu_idle | input | 1 | System idle indication |
| clk_sel | output | 3 | Frozen clock-source select toward the prescaler |
| wdt_req | output | 1 | One-cycle reset request |

## Verification
Two events can fall in the same cycle: a service write to the deadline, and the counter carrying from 0x01FF to 0x0200. The bench sets the counter to 0x01FF and the offset to 5, arms the watchdog, then raises a tick and the deadline write on the same edge. It judges the result by reading the deadline back as 0x06, which is the pre-increment upper byte plus the offset, while the counter reads 0x0200. A second overlap is a match edge that arrives while the counter keeps ticking. That case is checked by counting `wdt_req` pulses, which must total exactly one across the whole equality window.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int ADDR_W   = 3;
    localparam int CLKSEL_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL     = 3'd0,
        REG_RUN      = 3'd1,
        REG_CNT_LO   = 3'd2,
        REG_CNT_HI   = 3'd3,
        REG_CH_MODE  = 3'd4,
        REG_OFFSET   = 3'd5,
        REG_DEADLINE = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic                armed;
        logic [CLKSEL_W-1:0] clk_sel;
        logic                idle_sus;
        logic                run;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   mode;
        logic [BYTE_W-1:0]   offset;
        logic [BYTE_W-1:0]   deadline;
        logic                hit;
        logic                req;
    } wdog_state_t;
endpackage

// File: rtl/wdog_cmp.sv
module wdog_cmp
    import wdog_pkg::*;
(
    input  logic              armed,
    input  logic [BYTE_W-1:0] cnt_hi,
    input  logic [BYTE_W-1:0] deadline,
    input  logic [BYTE_W-1:0] offset,
    output logic              match,
    output logic [BYTE_W-1:0] reload
);
    // Equality of the upper counter byte and the deadline only counts while armed.
    assign match  = armed && (cnt_hi == deadline);
    // Relative deadline: wraps naturally in BYTE_W bits.
    assign reload = cnt_hi + offset;
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
    import wdog_pkg::*;
(
    input  logic [ADDR_W-1:0]   addr,
    input  logic                armed,
    input  logic [CLKSEL_W-1:0] clk_sel,
    input  logic                idle_sus,
    input  logic                run,
    input  logic [CNT_W-1:0]    cnt,
    input  logic [BYTE_W-1:0]   mode,
    input  logic [BYTE_W-1:0]   offset,
    input  logic [BYTE_W-1:0]   deadline,
    output logic [BYTE_W-1:0]   rdata
);
    localparam int CTRL_PAD = BYTE_W - CLKSEL_W - 2;

    always_comb begin
        rdata = '0;
        unique case (reg_addr_e'(addr))
            REG_CTRL:     rdata = {{CTRL_PAD{1'b0}}, idle_sus, clk_sel, armed};
            REG_RUN:      rdata = {{(BYTE_W-1){1'b0}}, run};
            REG_CNT_LO:   rdata = cnt[BYTE_W-1:0];
            REG_CNT_HI:   rdata = cnt[CNT_W-1:BYTE_W];
            REG_CH_MODE:  rdata = mode;
            REG_OFFSET:   rdata = offset;
            REG_DEADLINE: rdata = deadline;
            default:      rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase
    import wdog_pkg::*;
#(
    parameter logic [7:0] SWT_MODE = 8'h48
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BYTE_W-1:0]   bus_wdata,
    output logic [BYTE_W-1:0]   bus_rdata,
    input  logic                tb_tick,
    input  logic                cpu_idle,
    output logic [CLKSEL_W-1:0] clk_sel,
    output logic                wdt_req
);
    wdog_state_t st_d, st_q;
    logic              match;
    logic [BYTE_W-1:0] reload;

    wdog_cmp u_cmp (
        .armed    (st_q.armed),
        .cnt_hi   (st_q.cnt[CNT_W-1:BYTE_W]),
        .deadline (st_q.deadline),
        .offset   (st_q.offset),
        .match    (match),
        .reload   (reload)
    );

    wdog_rdmux u_rdmux (
        .addr     (bus_addr),
        .armed    (st_q.armed),
        .clk_sel  (st_q.clk_sel),
        .idle_sus (st_q.idle_sus),
        .run      (st_q.run),
        .cnt      (st_q.cnt),
        .mode     (st_q.mode),
        .offset   (st_q.offset),
        .deadline (st_q.deadline),
        .rdata    (bus_rdata)
    );

    always_comb begin
        logic advance;
        st_d    = st_q;
        advance = (st_q.armed || st_q.run) && tb_tick
                  && !(st_q.idle_sus && cpu_idle);
        if (advance) st_d.cnt = st_q.cnt + 1'b1;

        if (st_q.armed) st_d.mode = SWT_MODE;

        if (bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                REG_CTRL: begin
                    st_d.armed = bus_wdata[0];
                    if (!st_q.armed) begin
                        st_d.clk_sel  = bus_wdata[CLKSEL_W:1];
                        st_d.idle_sus = bus_wdata[CLKSEL_W+1];
                    end
                end
                REG_RUN:      st_d.run = bus_wdata[0];
                REG_CNT_LO:   if (!st_q.armed) st_d.cnt[BYTE_W-1:0]     = bus_wdata;
                REG_CNT_HI:   if (!st_q.armed) st_d.cnt[CNT_W-1:BYTE_W] = bus_wdata;
                REG_CH_MODE:  if (!st_q.armed) st_d.mode = bus_wdata;
                REG_OFFSET:   st_d.offset   = bus_wdata;
                REG_DEADLINE: st_d.deadline = reload;
                default: ;
            endcase
        end

        st_d.hit = match;
        st_d.req = match && !st_q.hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.armed    <= 1'b1;
            st_q.mode     <= SWT_MODE;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_sel = st_q.clk_sel;
    assign wdt_req = st_q.req;
endmodule

// File: rtl/wdog_timebase_chk.sv
module wdog_timebase_chk
    import wdog_pkg::*;
#(
    parameter logic [7:0] SWT_MODE = 8'h48
)(
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                tb_tick,
    input logic                cpu_idle,
    input logic                armed,
    input logic                idle_sus,
    input logic [CLKSEL_W-1:0] clk_sel,
    input logic [CNT_W-1:0]    cnt,
    input logic [BYTE_W-1:0]   mode,
    input logic [BYTE_W-1:0]   offset,
    input logic [BYTE_W-1:0]   deadline,
    input logic                wdt_req
);
    logic cnt_wr;
    assign cnt_wr = bus_wr && (bus_addr == REG_CNT_LO || bus_addr == REG_CNT_HI);

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |=> !wdt_req);

    assert_req_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req |-> $past(armed));

    assert_service_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == REG_DEADLINE) |=>
        deadline == BYTE_W'($past(cnt[CNT_W-1:BYTE_W]) + $past(offset)));

    assert_cnt_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && cnt_wr && !tb_tick) |=> $stable(cnt));

    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && bus_addr == REG_CTRL) |=> ($stable(clk_sel) && $stable(idle_sus)));

    assert_mode_pinned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && bus_wr && bus_addr == REG_CH_MODE) |=> mode == SWT_MODE);

    assert_forced_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tb_tick && !(idle_sus && cpu_idle) && !cnt_wr) |=>
        cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

bind wdog_timebase wdog_timebase_chk #(.SWT_MODE(SWT_MODE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .tb_tick  (tb_tick),
    .cpu_idle (cpu_idle),
    .armed    (st_q.armed),
    .idle_sus (st_q.idle_sus),
    .clk_sel  (st_q.clk_sel),
    .cnt      (st_q.cnt),
    .mode     (st_q.mode),
    .offset   (st_q.offset),
    .deadline (st_q.deadline),
    .wdt_req  (wdt_req)
);

// File: tb/wdog_timebase_bench.sv
`timescale 1ns/1ps
module wdog_timebase_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tb_tick = 1'b0;
    logic       cpu_idle = 1'b0;
    logic [2:0] clk_sel;
    logic       wdt_req;

    int tests = 0;
    int fails = 0;
    int req_seen = 0;
    int snap;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_timebase u_wdog_timebase (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tb_tick(tb_tick),
        .cpu_idle(cpu_idle), .clk_sel(clk_sel), .wdt_req(wdt_req)
    );

    always @(posedge clk) if (rst_n && wdt_req) req_seen++;

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [2:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        check(tag, {8'h00, bus_rdata}, {8'h00, exp});
    endtask

    // {wr, waddr, wdata, raddr, expected, requirement number}
    localparam logic [26:0] VEC [12] = '{
        {1'b0, 3'd1, 8'h00, 3'd1, 8'h00, 4'd4},  // R4 run reads 0 while forced on
        {1'b1, 3'd2, 8'h55, 3'd2, 8'h00, 4'd5},  // R5 low byte locked
        {1'b1, 3'd3, 8'h66, 3'd3, 8'h00, 4'd5},  // R5 high byte locked
        {1'b1, 3'd0, 8'h1F, 3'd0, 8'h01, 4'd6},  // R6 only arm bit moves
        {1'b1, 3'd4, 8'h00, 3'd4, 8'h48, 4'd7},  // R7 mode pinned
        {1'b1, 3'd5, 8'h30, 3'd5, 8'h30, 4'd9},  // R9 offset free
        {1'b1, 3'd6, 8'hAB, 3'd6, 8'h30, 4'd3},  // R3 deadline = 0 + 0x30
        {1'b1, 3'd0, 8'h00, 3'd0, 8'h00, 4'd8},  // R8 disarm
        {1'b1, 3'd4, 8'h11, 3'd4, 8'h11, 4'd7},  // R7 mode writable
        {1'b1, 3'd3, 8'h12, 3'd3, 8'h12, 4'd5},  // R5 high byte writable
        {1'b1, 3'd2, 8'h34, 3'd2, 8'h34, 4'd5},  // R5 low byte writable
        {1'b1, 3'd0, 8'h0A, 3'd0, 8'h0A, 4'd6}   // R6 clock select writable
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 ctrl", 3'd0, 8'h01);
        rd("R1 mode", 3'd4, 8'h48);
        rd("R1 deadline", 3'd6, 8'h00);
        check("R1 req idle", {15'd0, wdt_req}, 16'd0);
        @(negedge clk);
        check("R1 early req", {15'd0, wdt_req}, 16'd1);
        @(negedge clk);
        check("R2 single pulse", {15'd0, wdt_req}, 16'd0);

        foreach (VEC[i]) begin
            logic [26:0] v;
            string tag;
            v = VEC[i];
            if (v[26]) wr(v[25:23], v[22:15]);
            tag = $sformatf("R%0d vec%0d", v[3:0], i);
            rd(tag, v[14:12], v[11:4]);
        end
        check("R6 clk_sel pin", {13'd0, clk_sel}, 16'd5);

        // R8 disarmed, run=0: counter holds
        @(negedge clk); tb_tick = 1'b1;
        repeat (5) @(negedge clk);
        tb_tick = 1'b0;
        rd("R8 hold lo", 3'd2, 8'h34);
        wr(3'd1, 8'h01);
        tb_tick = 1'b1;
        repeat (10) @(negedge clk);
        tb_tick = 1'b0;
        rd("R8 run lo", 3'd2, 8'h3E);
        // R10 idle suspension
        wr(3'd0, 8'h10);
        cpu_idle = 1'b1; tb_tick = 1'b1;
        repeat (5) @(negedge clk);
        cpu_idle = 1'b0;
        repeat (3) @(negedge clk);
        tb_tick = 1'b0;
        rd("R10 idle hold", 3'd2, 8'h41);

        // R2 match timing
        wr(3'd1, 8'h00);
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h00);
        wr(3'd5, 8'h02);
        wr(3'd0, 8'h01);
        wr(3'd6, 8'h77);
        rd("R3 deadline", 3'd6, 8'h02);
        snap = req_seen;
        tb_tick = 1'b1;
        repeat (512) @(negedge clk);
        check("R2 no early req", {15'd0, wdt_req}, 16'd0);
        check("R4 forced run", 16'(req_seen - snap), 16'd0);
        @(negedge clk);
        check("R2 req on match", {15'd0, wdt_req}, 16'd1);
        repeat (20) @(negedge clk);
        tb_tick = 1'b0;
        check("R2 one pulse per match", 16'(req_seen - snap), 16'd1);

        // R3 service coincides with carry into upper byte
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h01);
        wr(3'd2, 8'hFF);
        wr(3'd5, 8'h05);
        wr(3'd0, 8'h01);
        @(negedge clk);
        tb_tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 8'hEE;
        @(negedge clk);
        tb_tick = 1'b0; bus_wr = 1'b0;
        rd("R3 collision deadline", 3'd6, 8'h06);
        rd("R3 collision cnt hi", 3'd3, 8'h02);
        rd("R3 collision cnt lo", 3'd2, 8'h00);

        // R3 wrap modulo 256
        wr(3'd5, 8'hFF);
        wr(3'd6, 8'h00);
        rd("R3 wrap", 3'd6, 8'h01);

        // R8 disarmed equality gives no request
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h01);
        snap = req_seen;
        repeat (4) @(negedge clk);
        check("R8 no req disarmed", 16'(req_seen - snap), 16'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule